// File: doc/BRIEF.md
# Storage Port Command and Status Register

This block holds the per-port command/status control word of a serial storage host port and carries out the side effects of its bits. Software writes the whole word through a single write strobe and reads it back through a combinational read path. The block then drives the port's control outputs:

- a run enable for the command-list engine;
- a pointer to the command slot being worked on;
- a one-cycle pulse that clears the issued-command vector;
- a reset request toward the link;
- a listen-mode request;
- an accept gate for incoming frames;
- the task-file BSY/DRQ status as software sees it, with a forced-clear override applied.

The fetch engine, frame parser, DMA and physical signalling lie outside the block. They appear only as handshake inputs and outputs.

Four small state machines drive this behaviour.

- **Run machine** (`run_state_t`). States are RS_IDLE, RS_RUN, RS_STOP and RS_CLEAR.
  - IDLE→RUN is taken when the start bit is set. This transition also zeroes the slot pointer.
  - RUN→STOP is taken when start is cleared.
  - STOP→CLEAR is taken when the engine reports idle.
  - CLEAR→IDLE is taken unconditionally one cycle later.
- **Spin-up machine** (`spin_state_t`). States are SU_DOWN and SU_UP.
  - DOWN→UP is taken on a write of 1. It issues the reset request.
  - UP→DOWN is taken on a write of 0. It issues a listen request if the detect-control field is zero.
- **Frame gate** (`fis_state_t`). States are FG_SHUT and FG_ARMED.
  - SHUT→ARMED is taken on a link-ready pulse.
  - ARMED→SHUT is taken when the first device-to-host register frame arrives.
- **Override bit** (`ovr_state_t`). States are OV_OFF and OV_ON.
  - OFF→ON is taken on a write of 1.
  - ON→OFF is taken once the raw BSY and DRQ are both 0.

Top module: `port_cmd_ctrl`

## Requirements
- R1: After reset, the read word is 0x0004 when the stagger strap is 1. Bit layout: bit0 start, bit1 spin-up, bit2 power-on-device, bit3 override, bit4 frame-receive enable, bits 12:8 current slot, bit14 the `fis_running` input. Bit2 always reads 1. Bits 7:5, 13 and 15 always read 0.
- R2: A write that sets start (bit0) raises `run_en` one cycle after start reads 1. At that point `cur_slot` is 0, even if the pointer held another value before.
- R3: While running, each `slot_done` cycle moves `cur_slot` to the next set bit of `issued` above the current slot, wrapping from 31 to 0. If no bit of `issued` is set, the pointer stays where it is.
- R4: Bits 12:8 of the read word show `cur_slot` while start is 1, and read 0 while start is 0.
- R5: After a write that clears start, `run_en` drops one cycle later. `ci_clear` stays low until `eng_idle` is seen high. It then pulses for exactly one cycle, in the cycle after `eng_idle` is sampled.
- R6: Writing 1 to bit3 sets the override. While it is set, `tf_bsy_out` and `tf_drq_out` are 0 whatever the raw inputs are.
- R7: The override clears itself in the cycle after the raw `tf_bsy` and `tf_drq` are both 0. Writing 0 to bit3 leaves it unchanged.
- R8: While frame-receive enable (bit4) is 0, `fis_accept` is 0 except under R9. While it is 1, `fis_accept` follows `rx_valid`.
- R9: After a `link_ready` pulse, the first frame with `rx_is_d2h` set is accepted even with receive enable at 0. It is the only one until the next `link_ready`.
- R10: With the stagger strap at 1, spin-up (bit1) is read/write and resets to 0. With the strap at 0, it reads 1 and writes have no effect.
- R11: A write that takes spin-up from 0 to 1 produces a one-cycle `comreset_req` pulse in the cycle after the write. A write of 1 while it is already 1, and a write of 0, produce no pulse.
- R12: A write that takes spin-up from 1 to 0 pulses `listen_req` for one cycle when `det_zero` is 1. It produces no pulse when `det_zero` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 5 | Write value for bits 4:0 |
| rd_data | output | 16 | Register read value |
| cap_stagger | input | 1 | Staggered spin-up capability strap |
| det_zero | input | 1 | Device-detect control field equals zero |
| tf_bsy | input | 1 | Raw task-file BSY |
| tf_drq | input | 1 | Raw task-file DRQ |
| eng_idle | input | 1 | Port engine has reached idle |
| slot_done | input | 1 | Engine finished the current slot |
| issued | input | 32 | Issued-command vector |
| fis_running | input | 1 | Frame receive engine running |
| link_ready | input | 1 | Link initialisation completed (pulse) |
| rx_valid | input | 1 | Frame offered by the link |
| rx_is_d2h | input | 1 | Offered frame is a device-to-host register frame |
| run_en | output | 1 | Command-list processing enable |
| cur_slot | output | 5 | Current command slot |
| ci_clear | output | 1 | Clear the issued-command vector (pulse) |
| comreset_req | output | 1 | Link reset request (pulse) |
| listen_req | output | 1 | Listen-mode request (pulse) |
| fis_accept | output | 1 | Accept the offered frame |
| tf_bsy_out | output | 1 | BSY after override |
| tf_drq_out | output | 1 | DRQ after override |

## Verification
The assertions assume the following about the inputs:
- The strap `cap_stagger` changes only under reset.
- `link_ready` is a pulse.
- Software clears start only after setting it.

The run-machine checks take `eng_idle` as meaningful only while the machine sits in RS_STOP. The bench holds the strap fixed inside each reset phase and changes it only around a fresh reset. It drives `link_ready` for a single cycle. It sweeps the slot pointer over a set of sparse, dense, empty and wrap-around `issued` masks, with the expected next slot computed arithmetically. The frame and task-file inputs are changed only away from the clock edge.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
    localparam int REG_W   = 16;
    localparam int WR_W    = 5;
    localparam int B_START = 0;
    localparam int B_SPIN  = 1;
    localparam int B_POWER = 2;
    localparam int B_OVR   = 3;
    localparam int B_FRE   = 4;
    localparam int B_SLOT  = 8;
    localparam int B_FRUN  = 14;

    typedef enum logic [1:0] {RS_IDLE, RS_RUN, RS_STOP, RS_CLEAR} run_state_t;
    typedef enum logic {SU_DOWN, SU_UP} spin_state_t;
    typedef enum logic {FG_SHUT, FG_ARMED} fis_state_t;
    typedef enum logic {OV_OFF, OV_ON} ovr_state_t;
endpackage

// File: rtl/pcc_run_fsm.sv
module pcc_run_fsm
    import pcc_pkg::*;
#(
    parameter int SLOT_W = 5,
    localparam int NSLOT = 1 << SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              eng_idle,
    input  logic              slot_done,
    input  logic [NSLOT-1:0]  issued,
    output logic              run_en,
    output logic              ci_clear,
    output logic [SLOT_W-1:0] cur_slot
);
    run_state_t state, state_nx;
    logic [SLOT_W-1:0] slot_nx;

    function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] cur,
                                                    input logic [NSLOT-1:0] vec);
        logic [SLOT_W-1:0] res;
        logic              hit;
        res = cur;
        hit = 1'b0;
        for (int i = 1; i <= NSLOT; i++) begin
            logic [SLOT_W-1:0] idx;
            idx = cur + SLOT_W'(i);
            if (!hit && vec[idx]) begin
                res = idx;
                hit = 1'b1;
            end
        end
        return res;
    endfunction

    always_comb begin
        state_nx = state;
        slot_nx  = cur_slot;
        unique case (state)
            RS_IDLE:  if (start) begin
                          state_nx = RS_RUN;
                          slot_nx  = '0;
                      end
            RS_RUN:   if (!start)        state_nx = RS_STOP;
                      else if (slot_done) slot_nx = next_slot(cur_slot, issued);
            RS_STOP:  if (eng_idle)      state_nx = RS_CLEAR;
            RS_CLEAR:                    state_nx = RS_IDLE;
            default:                     state_nx = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RS_IDLE;
            cur_slot <= '0;
        end else begin
            state    <= state_nx;
            cur_slot <= slot_nx;
        end
    end

    always_comb begin
        run_en   = (state == RS_RUN);
        ci_clear = (state == RS_CLEAR);
    end

    a_r5_clear_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ci_clear |-> $past(eng_idle));
    a_r5_clear_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ci_clear |=> !ci_clear);
    a_r2_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> (cur_slot == '0));
    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !slot_done) |=> $stable(cur_slot));
endmodule

// File: rtl/pcc_spinup.sv
module pcc_spinup
    import pcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_spin,
    input  logic cap_stagger,
    input  logic det_zero,
    output logic spin_rd,
    output logic comreset_req,
    output logic listen_req
);
    spin_state_t state, state_nx;
    logic        rise_nx, fall_nx;

    always_comb begin
        state_nx = state;
        rise_nx  = 1'b0;
        fall_nx  = 1'b0;
        if (wr_en && cap_stagger) begin
            unique case (state)
                SU_DOWN: if (wr_spin) begin
                             state_nx = SU_UP;
                             rise_nx  = 1'b1;
                         end
                SU_UP:   if (!wr_spin) begin
                             state_nx = SU_DOWN;
                             fall_nx  = det_zero;
                         end
                default: state_nx = SU_DOWN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SU_DOWN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comreset_req <= 1'b0;
            listen_req   <= 1'b0;
        end else begin
            comreset_req <= rise_nx;
            listen_req   <= fall_nx;
        end
    end

    assign spin_rd = cap_stagger ? (state == SU_UP) : 1'b1;

    a_r11_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        comreset_req |=> !comreset_req);
    a_r11_reset_needs_strap: assert property (@(posedge clk) disable iff (!rst_n)
        comreset_req |-> $past(cap_stagger) && $past(wr_en));
    a_r12_listen_needs_detect: assert property (@(posedge clk) disable iff (!rst_n)
        listen_req |-> $past(det_zero) && !comreset_req);
endmodule

// File: rtl/pcc_fis_gate.sv
module pcc_fis_gate
    import pcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_fre,
    input  logic link_ready,
    input  logic rx_valid,
    input  logic rx_is_d2h,
    output logic fre,
    output logic fis_accept
);
    fis_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            FG_SHUT:  if (link_ready) state_nx = FG_ARMED;
            FG_ARMED: if (link_ready) state_nx = FG_ARMED;
                      else if (rx_valid && rx_is_d2h) state_nx = FG_SHUT;
            default:  state_nx = FG_SHUT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FG_SHUT;
            fre   <= 1'b0;
        end else begin
            state <= state_nx;
            if (wr_en) fre <= wr_fre;
        end
    end

    always_comb begin
        fis_accept = rx_valid && (fre || (state == FG_ARMED && rx_is_d2h));
    end

    a_r8_refuse_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (fis_accept && !fre) |-> rx_is_d2h);
    a_r9_once_per_link: assert property (@(posedge clk) disable iff (!rst_n)
        (fis_accept && !fre && !link_ready) |=> !(fis_accept && !fre && !link_ready && $past(!link_ready)));
endmodule

// File: rtl/port_cmd_ctrl.sv
module port_cmd_ctrl
    import pcc_pkg::*;
#(
    parameter int SLOT_W = 5,
    localparam int NSLOT = 1 << SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WR_W-1:0]   wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              cap_stagger,
    input  logic              det_zero,
    input  logic              tf_bsy,
    input  logic              tf_drq,
    input  logic              eng_idle,
    input  logic              slot_done,
    input  logic [NSLOT-1:0]  issued,
    input  logic              fis_running,
    input  logic              link_ready,
    input  logic              rx_valid,
    input  logic              rx_is_d2h,
    output logic              run_en,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              ci_clear,
    output logic              comreset_req,
    output logic              listen_req,
    output logic              fis_accept,
    output logic              tf_bsy_out,
    output logic              tf_drq_out
);
    logic       start;
    logic       spin_rd;
    logic       fre;
    logic       wr_unused;
    ovr_state_t ovr, ovr_nx;

    assign wr_unused = wr_data[B_POWER];

    always_ff @(posedge clk) begin
        if (!rst_n)     start <= 1'b0;
        else if (wr_en) start <= wr_data[B_START];
    end

    always_comb begin
        ovr_nx = ovr;
        unique case (ovr)
            OV_OFF:  if (wr_en && wr_data[B_OVR]) ovr_nx = OV_ON;
            OV_ON:   if (!tf_bsy && !tf_drq)      ovr_nx = OV_OFF;
            default: ovr_nx = OV_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ovr <= OV_OFF;
        else        ovr <= ovr_nx;
    end

    always_comb begin
        tf_bsy_out = tf_bsy && (ovr == OV_OFF);
        tf_drq_out = tf_drq && (ovr == OV_OFF);
    end

    pcc_run_fsm #(.SLOT_W(SLOT_W)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .eng_idle  (eng_idle),
        .slot_done (slot_done),
        .issued    (issued),
        .run_en    (run_en),
        .ci_clear  (ci_clear),
        .cur_slot  (cur_slot)
    );

    pcc_spinup u_spin (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_spin      (wr_data[B_SPIN]),
        .cap_stagger  (cap_stagger),
        .det_zero     (det_zero),
        .spin_rd      (spin_rd),
        .comreset_req (comreset_req),
        .listen_req   (listen_req)
    );

    pcc_fis_gate u_fis (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_fre     (wr_data[B_FRE]),
        .link_ready (link_ready),
        .rx_valid   (rx_valid),
        .rx_is_d2h  (rx_is_d2h),
        .fre        (fre),
        .fis_accept (fis_accept)
    );

    always_comb begin
        rd_data          = '0;
        rd_data[B_START] = start;
        rd_data[B_SPIN]  = spin_rd;
        rd_data[B_POWER] = 1'b1;
        rd_data[B_OVR]   = (ovr == OV_ON);
        rd_data[B_FRE]   = fre;
        rd_data[B_SLOT +: SLOT_W] = start ? cur_slot : '0;
        rd_data[B_FRUN]  = fis_running;
    end

    a_r6_override_masks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[B_OVR]) |-> !tf_bsy_out && !tf_drq_out);
    a_r7_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr == OV_ON && !tf_bsy && !tf_drq) |=> !rd_data[B_OVR]);
    a_r7_zero_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr == OV_ON && (tf_bsy || tf_drq)) |=> rd_data[B_OVR]);
    a_r1_power_bit: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[B_POWER] && rd_data[7:5] == 3'b000);
endmodule

// File: tb/sim_port_cmd_ctrl.sv
module sim_port_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_data = '0;
    logic [15:0] rd_data;
    logic        cap_stagger = 1'b1, det_zero = 1'b0, tf_bsy = 1'b0, tf_drq = 1'b0;
    logic        eng_idle = 1'b0, slot_done = 1'b0, fis_running = 1'b0;
    logic        link_ready = 1'b0, rx_valid = 1'b0, rx_is_d2h = 1'b0;
    logic [31:0] issued = '0;
    logic        run_en, ci_clear, comreset_req, listen_req, fis_accept, tf_bsy_out, tf_drq_out;
    logic [4:0]  cur_slot;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    port_cmd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .cap_stagger(cap_stagger), .det_zero(det_zero), .tf_bsy(tf_bsy), .tf_drq(tf_drq),
        .eng_idle(eng_idle), .slot_done(slot_done), .issued(issued), .fis_running(fis_running),
        .link_ready(link_ready), .rx_valid(rx_valid), .rx_is_d2h(rx_is_d2h),
        .run_en(run_en), .cur_slot(cur_slot), .ci_clear(ci_clear), .comreset_req(comreset_req),
        .listen_req(listen_req), .fis_accept(fis_accept), .tf_bsy_out(tf_bsy_out),
        .tf_drq_out(tf_drq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] v);
        wr_en = 1'b1;
        wr_data = v;
        tick();
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic do_reset(input logic cap);
        cap_stagger = cap;
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    function automatic logic [4:0] exp_next(input logic [4:0] cur, input logic [31:0] m);
        if (m == 0) return cur;
        for (int k = 1; k <= 32; k++)
            if (m[(cur + k) % 32]) return 5'((cur + k) % 32);
        return cur;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] masks [6];
        logic [4:0]  es;
        masks[0] = 32'h0000_0000; masks[1] = 32'h0000_0001; masks[2] = 32'h8000_0001;
        masks[3] = 32'hA5A5_0F0F; masks[4] = 32'hFFFF_FFFF; masks[5] = 32'h0010_0100;

        #1;
        do_reset(1'b1);
        // R1: reset read word and layout
        chk("R1 reset word", {16'h0, rd_data}, 32'h0004);
        chk("R1 outputs idle", {run_en, ci_clear, comreset_req, listen_req}, 0);
        fis_running = 1'b1;
        #1;
        chk("R1 running flag bit14", {16'h0, rd_data}, 32'h4004);
        fis_running = 1'b0;

        // R2: start
        wr(5'b00001);
        chk("R2 run not yet", run_en, 0);
        tick();
        chk("R2 run_en", run_en, 1);
        chk("R2 slot zero", cur_slot, 0);

        // R3/R4: slot advance sweep
        es = 0;
        foreach (masks[mi]) begin
            issued = masks[mi];
            for (int s = 0; s < 40; s++) begin
                slot_done = 1'b1;
                tick();
                slot_done = 1'b0;
                es = exp_next(es, masks[mi]);
                chk("R3 slot advance", cur_slot, es);
                chk("R4 slot field", rd_data[12:8], es);
            end
        end
        issued = 32'h0000_0040;
        slot_done = 1'b1;
        tick();
        slot_done = 1'b0;
        chk("R3 to slot 6", cur_slot, 6);

        // R5: stop, deferred clear
        wr(5'b00000);
        chk("R4 field zero when stopped", rd_data[12:8], 0);
        tick();
        chk("R5 run_en dropped", run_en, 0);
        for (int i = 0; i < 5; i++) begin
            chk("R5 clear held off", ci_clear, 0);
            tick();
        end
        eng_idle = 1'b1;
        tick();
        eng_idle = 1'b0;
        chk("R5 clear pulse", ci_clear, 1);
        tick();
        chk("R5 clear single", ci_clear, 0);

        // R2: restart from a nonzero slot
        wr(5'b00001);
        tick();
        chk("R2 restart slot zero", cur_slot, 0);
        wr(5'b00000);
        eng_idle = 1'b1;
        tick(); tick(); tick();
        eng_idle = 1'b0;

        // R6/R7: override
        tf_bsy = 1'b1; tf_drq = 1'b1;
        #1;
        chk("R6 raw passes", {tf_bsy_out, tf_drq_out}, 2'b11);
        wr(5'b01000);
        chk("R6 forced zero", {tf_bsy_out, tf_drq_out}, 2'b00);
        chk("R6 bit3 set", rd_data[3], 1);
        tick();
        tf_bsy = 1'b0;
        tick();
        chk("R7 stays while drq", rd_data[3], 1);
        wr(5'b00000);
        chk("R7 zero write no effect", rd_data[3], 1);
        tf_drq = 1'b0;
        tick();
        chk("R7 self clear", rd_data[3], 0);
        tf_bsy = 1'b1;
        #1;
        chk("R7 raw back", tf_bsy_out, 1);
        tf_bsy = 1'b0;

        // R8/R9: frame gate
        rx_valid = 1'b1; rx_is_d2h = 1'b0;
        #1;
        chk("R8 refused other", fis_accept, 0);
        rx_is_d2h = 1'b1;
        #1;
        chk("R8 refused d2h unarmed", fis_accept, 0);
        rx_valid = 1'b0;
        link_ready = 1'b1;
        tick();
        link_ready = 1'b0;
        rx_valid = 1'b1; rx_is_d2h = 1'b0;
        #1;
        chk("R9 non-d2h still refused", fis_accept, 0);
        tick();
        rx_is_d2h = 1'b1;
        #1;
        chk("R9 first d2h accepted", fis_accept, 1);
        tick();
        chk("R9 second d2h refused", fis_accept, 0);
        wr(5'b10000);
        rx_is_d2h = 1'b0;
        #1;
        chk("R8 enabled accepts", fis_accept, 1);
        rx_valid = 1'b0;
        #1;
        chk("R8 follows valid", fis_accept, 0);
        wr(5'b00000);

        // R10/R11/R12 with strap 1
        det_zero = 1'b0;
        wr(5'b00010);
        chk("R10 spin reads 1", rd_data[1], 1);
        chk("R11 reset pulse", comreset_req, 1);
        tick();
        chk("R11 pulse ends", comreset_req, 0);
        wr(5'b00010);
        chk("R11 no repeat pulse", comreset_req, 0);
        wr(5'b00000);
        chk("R12 no listen without detect", listen_req, 0);
        chk("R11 no pulse on clear", comreset_req, 0);
        chk("R10 spin cleared", rd_data[1], 0);
        wr(5'b00010);
        det_zero = 1'b1;
        wr(5'b00000);
        chk("R12 listen pulse", listen_req, 1);
        tick();
        chk("R12 listen single", listen_req, 0);
        det_zero = 1'b0;

        // R10 with strap 0
        do_reset(1'b0);
        chk("R10 strap0 reset word", {16'h0, rd_data}, 32'h0006);
        det_zero = 1'b1;
        wr(5'b00000);
        chk("R10 strap0 write ignored", rd_data[1], 1);
        chk("R12 strap0 no listen", listen_req, 0);
        wr(5'b00010);
        chk("R11 strap0 no reset pulse", comreset_req, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule